// File: doc/BRIEF.md
# Blit Descriptor Ring Walker

This block feeds a 2D copy engine from a ring of command descriptors kept in external word-addressed memory. Software appends eight-word descriptors to the ring and pulses a kick input. The walker then processes live descriptors one after another, with no further software help. For each one it presents the copy parameters to the copy engine and waits for that copy to finish. It then retires the slot and moves to the next one. Consecutive descriptors may name different source and destination planes.

The last word of each descriptor is its validity word, and zero means empty. The walker reads that word first, and it reads the rest of the descriptor only when the word is non-zero. Software writes the validity word last, so a descriptor that is only half written is never used. When the walker meets an empty slot it parks on that slot and goes idle. The next kick makes it look at the same slot again. After a copy completes, the walker writes zero into the slot's validity word, so the slot reads as empty the next time the ring comes round.

Top module: `blit_ring_walker`

## Requirements
- R1: After reset, `busy_o`, `mem_req_o` and `blit_valid_o` are low and the current slot is 0.
- R2: Word w (0..7) of slot s is read or written at memory address `ring_base_i + 8*s + w`.
- R3: The validity word (word 7) of a slot is fetched before any other word of that slot. If it reads zero, no other word of that slot is read, no copy is issued, and the walker parks on that slot.
- R4: For a non-zero validity word, words 0..5 are read and a copy is presented with source=w0, source stride=w1, destination=w2, destination stride=w3, width=w4, height=w5 and control=w7. `blit_valid_o` and all parameters stay constant until `blit_done_i` is sampled high, and no memory request is made meanwhile.
- R5: After `blit_done_i`, the walker writes zero to word 7 of the same slot and then advances to the next slot.
- R6: Slots are processed strictly in order, and slot `RING_SLOTS-1` is followed by slot 0.
- R7: A kick while parked starts a new fetch of the validity word of the parked slot.
- R8: A kick received while busy is held. When the walker would otherwise park, it makes exactly one extra check of the current slot. Several kicks during one busy period still give a single extra check.
- R9: `busy_o` rises in the cycle after a kick is accepted and falls when the walker parks. While it is low, no memory request and no copy command are issued.
- R10: A memory request holds its address, direction and data until it is granted, and at most one read is outstanding.
- R11: Word 6 of a descriptor is never accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kick_i | input | 1 | Single-cycle pulse: re-examine the ring |
| ring_base_i | input | ADDR_W | Word address of slot 0 |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Word address |
| mem_wdata_o | output | DATA_W | Write data (always zero) |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| blit_valid_o | output | 1 | Copy command presented |
| blit_done_i | input | 1 | Copy finished (one-cycle pulse) |
| blit_src_o | output | DATA_W | Source address |
| blit_src_stride_o | output | DATA_W | Source stride |
| blit_dst_o | output | DATA_W | Destination address |
| blit_dst_stride_o | output | DATA_W | Destination stride |
| blit_width_o | output | DATA_W | Copy width |
| blit_height_o | output | DATA_W | Copy height |
| blit_ctrl_o | output | DATA_W | Control / validity word |
| busy_o | output | 1 | Walker active |

## Verification
The bench first kicks an empty ring, then runs a burst of live descriptors that ends on an empty slot, then refills across the wrap point so that the parked slot and slot 0 run in order. A walker that advanced past an empty slot, or forgot where it parked, would skip or repeat copies. A half-written slot, with its body present but a zero validity word, must cost exactly one read; a walker that fetched the body first would show extra reads. Two kicks during a copy must cause exactly two reads of the next empty slot's validity word, which catches both a lost kick and an unmerged one. A run with grants stalling every other cycle catches requests that drift or are dropped before they are granted. Retired slots are checked for a zero validity word, and word 6 is checked for no access at all.

// File: rtl/brw_pkg.sv
package brw_pkg;
  localparam int unsigned DESC_WORDS = 8;
  localparam int unsigned VALID_WORD = 7;
  localparam int unsigned BODY_WORDS = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHK_REQ,
    ST_CHK_WAIT,
    ST_BODY_REQ,
    ST_BODY_WAIT,
    ST_BLIT,
    ST_CLR
  } state_e;
endpackage

// File: rtl/brw_slot_ptr.sv
module brw_slot_ptr #(
  parameter int unsigned SLOTS  = 1024,
  parameter int unsigned SLOT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_q, slot_nx;

  generate
    if ((SLOTS & (SLOTS - 1)) == 0) begin : g_pow2
      assign slot_nx = slot_q + 1'b1;
    end else begin : g_wrap
      assign slot_nx = (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    slot_q <= '0;
    else if (adv_i) slot_q <= slot_nx;
  end

  assign slot_o = slot_q;
endmodule

// File: rtl/brw_kick_latch.sv
module brw_kick_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_o <= 1'b0;
    else if (clr_i) pend_o <= 1'b0;  // consume wins over a same-cycle kick
    else if (set_i) pend_o <= 1'b1;
  end
endmodule

// File: rtl/brw_desc_regs.sv
module brw_desc_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 6,
  parameter int unsigned IDX_W  = 3
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [DATA_W-1:0]            d_i,
  output logic [WORDS-1:0][DATA_W-1:0] words_o
);
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             words_o[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))     words_o[g] <= d_i;
    end
  end
endmodule

// File: rtl/blit_ring_walker.sv
module blit_ring_walker
  import brw_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned RING_SLOTS = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kick_i,
  input  logic [ADDR_W-1:0] ring_base_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              blit_valid_o,
  input  logic              blit_done_i,
  output logic [DATA_W-1:0] blit_src_o,
  output logic [DATA_W-1:0] blit_src_stride_o,
  output logic [DATA_W-1:0] blit_dst_o,
  output logic [DATA_W-1:0] blit_dst_stride_o,
  output logic [DATA_W-1:0] blit_width_o,
  output logic [DATA_W-1:0] blit_height_o,
  output logic [DATA_W-1:0] blit_ctrl_o,
  output logic              busy_o
);
  localparam int unsigned SLOT_W = (RING_SLOTS > 1) ? $clog2(RING_SLOTS) : 1;
  localparam int unsigned WORD_W = $clog2(DESC_WORDS);
  localparam int unsigned OFF_W  = SLOT_W + WORD_W;

  state_e state_q, state_d;
  logic [WORD_W-1:0] idx_q, word_sel;
  logic [DATA_W-1:0] ctrl_q;
  logic [SLOT_W-1:0] slot;
  logic [OFF_W-1:0]  word_off;
  logic [BODY_WORDS-1:0][DATA_W-1:0] body;
  logic advance, pend, kick_set, kick_clr, desc_we, last_body;

  brw_slot_ptr #(.SLOTS(RING_SLOTS), .SLOT_W(SLOT_W)) u_slot (
    .clk_i, .rst_ni, .adv_i(advance), .slot_o(slot)
  );

  brw_kick_latch u_kick (
    .clk_i, .rst_ni, .set_i(kick_set), .clr_i(kick_clr), .pend_o(pend)
  );

  brw_desc_regs #(.DATA_W(DATA_W), .WORDS(BODY_WORDS), .IDX_W(WORD_W)) u_regs (
    .clk_i, .rst_ni, .we_i(desc_we), .idx_i(idx_q), .d_i(mem_rdata_i), .words_o(body)
  );

  assign last_body = (idx_q == WORD_W'(BODY_WORDS - 1));
  assign kick_set  = kick_i && (state_q != ST_IDLE);

  always_comb begin
    state_d  = state_q;
    advance  = 1'b0;
    kick_clr = 1'b0;
    desc_we  = 1'b0;
    unique case (state_q)
      ST_IDLE:      if (kick_i) state_d = ST_CHK_REQ;
      ST_CHK_REQ:   if (mem_gnt_i) state_d = ST_CHK_WAIT;
      ST_CHK_WAIT:
        if (mem_rvalid_i) begin
          if (mem_rdata_i == '0) begin
            kick_clr = 1'b1;
            state_d  = (pend || kick_i) ? ST_CHK_REQ : ST_IDLE;
          end else begin
            state_d = ST_BODY_REQ;
          end
        end
      ST_BODY_REQ:  if (mem_gnt_i) state_d = ST_BODY_WAIT;
      ST_BODY_WAIT:
        if (mem_rvalid_i) begin
          desc_we = 1'b1;
          state_d = last_body ? ST_BLIT : ST_BODY_REQ;
        end
      ST_BLIT:      if (blit_done_i) state_d = ST_CLR;
      ST_CLR:
        if (mem_gnt_i) begin
          advance = 1'b1;
          state_d = ST_CHK_REQ;
        end
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      ctrl_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CHK_WAIT && mem_rvalid_i && mem_rdata_i != '0) begin
        idx_q  <= '0;
        ctrl_q <= mem_rdata_i;
      end else if (desc_we) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign word_sel    = (state_q == ST_BODY_REQ) ? idx_q : WORD_W'(VALID_WORD);
  assign word_off    = {slot, word_sel};
  assign mem_req_o   = (state_q == ST_CHK_REQ) || (state_q == ST_BODY_REQ) || (state_q == ST_CLR);
  assign mem_we_o    = (state_q == ST_CLR);
  assign mem_addr_o  = ring_base_i + ADDR_W'(word_off);
  assign mem_wdata_o = '0;

  assign blit_valid_o      = (state_q == ST_BLIT);
  assign blit_src_o        = body[0];
  assign blit_src_stride_o = body[1];
  assign blit_dst_o        = body[2];
  assign blit_dst_stride_o = body[3];
  assign blit_width_o      = body[4];
  assign blit_height_o     = body[5];
  assign blit_ctrl_o       = ctrl_q;
  assign busy_o            = (state_q != ST_IDLE);
endmodule

// File: rtl/brw_checker.sv
module brw_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] ring_base_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_gnt_i,
  input logic              blit_valid_o,
  input logic              blit_done_i,
  input logic [DATA_W-1:0] blit_src_o,
  input logic [DATA_W-1:0] blit_dst_o,
  input logic [DATA_W-1:0] blit_ctrl_o,
  input logic              busy_o
);
  logic [ADDR_W-1:0] rel;
  assign rel = mem_addr_o - ring_base_i;

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r4_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blit_valid_o && !blit_done_i |=> blit_valid_o && $stable(blit_src_o)
      && $stable(blit_dst_o) && $stable(blit_ctrl_o));

  a_r4_no_mem_in_blit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blit_valid_o |-> !mem_req_o);

  a_r5_clear_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wdata_o == '0 && rel[2:0] == 3'd7);

  a_r9_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !blit_valid_o);

  a_r11_skip_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> rel[2:0] != 3'd6);

  a_r5_done_to_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blit_valid_o && blit_done_i |=> mem_req_o && mem_we_o);
endmodule

bind blit_ring_walker brw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/blit_ring_walker_test.sv
`timescale 1ns/1ps
module blit_ring_walker_test;
  localparam int AW = 32, DW = 32, SLOTS = 4, BASE = 16;

  logic clk = 0, rst_n = 0, kick = 0;
  logic mem_req, mem_we, gnt = 1, rvalid = 0, blit_valid, blit_done = 0, busy;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, rdata = 0;
  logic [DW-1:0] b_src, b_ss, b_dst, b_ds, b_w, b_h, b_ctrl;

  always #2 clk = ~clk;

  blit_ring_walker #(.ADDR_W(AW), .DATA_W(DW), .RING_SLOTS(SLOTS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .kick_i(kick), .ring_base_i(AW'(BASE)),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(gnt), .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
    .blit_valid_o(blit_valid), .blit_done_i(blit_done),
    .blit_src_o(b_src), .blit_src_stride_o(b_ss), .blit_dst_o(b_dst), .blit_dst_stride_o(b_ds),
    .blit_width_o(b_w), .blit_height_o(b_h), .blit_ctrl_o(b_ctrl), .busy_o(busy)
  );

  // memory, host write port, access counters
  logic [DW-1:0] mem [64];
  int rd_cnt [64];
  int rd_tot, wr_tot;
  logic host_we = 0, host_clr = 0, stall = 0;
  int host_a = 0;
  logic [DW-1:0] host_d = 0;

  always @(posedge clk) begin
    rvalid <= 1'b0;
    gnt    <= stall ? ~gnt : 1'b1;
    if (host_we) mem[host_a] <= host_d;
    if (host_clr) begin
      for (int i = 0; i < 64; i++) rd_cnt[i] <= 0;
      rd_tot <= 0; wr_tot <= 0;
    end else if (mem_req && gnt) begin
      if (mem_we) begin
        mem[mem_addr[5:0]] <= mem_wdata;
        wr_tot <= wr_tot + 1;
      end else begin
        rvalid <= 1'b1;
        rdata  <= mem[mem_addr[5:0]];
        rd_cnt[mem_addr[5:0]] <= rd_cnt[mem_addr[5:0]] + 1;
        rd_tot <= rd_tot + 1;
      end
    end
  end

  // copy engine model: done three cycles into each command
  logic [DW-1:0] lg_src [16], lg_ss [16], lg_dst [16], lg_ds [16], lg_w [16], lg_h [16], lg_c [16];
  int log_n, bcnt;
  always @(posedge clk) begin
    blit_done <= 1'b0;
    if (host_clr) log_n <= 0;
    if (blit_valid && !blit_done) begin
      if (bcnt == 3) begin
        blit_done <= 1'b1; bcnt <= 0;
        lg_src[log_n] <= b_src; lg_ss[log_n] <= b_ss; lg_dst[log_n] <= b_dst;
        lg_ds[log_n] <= b_ds; lg_w[log_n] <= b_w; lg_h[log_n] <= b_h; lg_c[log_n] <= b_ctrl;
        log_n <= log_n + 1;
      end else bcnt <= bcnt + 1;
    end
  end

  int total = 0, bad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); host_we = 1; host_a = a; host_d = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic clr_stats();
    @(negedge clk); host_clr = 1;
    @(negedge clk); host_clr = 0;
  endtask

  function automatic int wa(input int s, input int w);
    return BASE + 8 * s + w;
  endfunction

  task automatic put_desc(input int s, input int tag);
    wr(wa(s, 0), 32'h1000 + tag); wr(wa(s, 1), 32'h20 + tag);
    wr(wa(s, 2), 32'h2000 + tag); wr(wa(s, 3), 32'h40 + tag);
    wr(wa(s, 4), 8 + tag);        wr(wa(s, 5), 12 + tag);
    wr(wa(s, 6), 32'hDEAD);
    wr(wa(s, 7), 32'hC0 + tag);   // validity word last
  endtask

  task automatic chk_log(input int i, input int tag);
    check("R4 src", lg_src[i], 32'h1000 + tag);
    check("R4 src_stride", lg_ss[i], 32'h20 + tag);
    check("R4 dst", lg_dst[i], 32'h2000 + tag);
    check("R4 dst_stride", lg_ds[i], 32'h40 + tag);
    check("R4 width", lg_w[i], 8 + tag);
    check("R4 height", lg_h[i], 12 + tag);
    check("R4 ctrl", lg_c[i], 32'hC0 + tag);
  endtask

  task automatic kick_and_wait();
    @(negedge clk); kick = 1;
    @(negedge clk); kick = 0;
    check("R9 busy after kick", 32'(busy), 1);
    for (int i = 0; i < 3000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    check("R9 parked idle", 32'(busy), 0);
  endtask

  task automatic t_reset();
    check("R1 busy", 32'(busy), 0);
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 blit_valid", 32'(blit_valid), 0);
  endtask

  task automatic t_empty();
    clr_stats();
    kick_and_wait();
    check("R3 single read", rd_tot, 1);
    check("R2 R1 slot0 valid word read", rd_cnt[wa(0, 7)], 1);
    check("R3 no copy", log_n, 0);
  endtask

  task automatic t_burst();
    put_desc(0, 1); put_desc(1, 2); put_desc(2, 3);
    clr_stats();
    kick_and_wait();
    check("R6 copies", log_n, 3);
    chk_log(0, 1); chk_log(1, 2); chk_log(2, 3);
    for (int s = 0; s < 3; s++) begin
      check("R5 retired", mem[wa(s, 7)], 0);
      check("R11 reserved untouched", rd_cnt[wa(s, 6)], 0);
      check("R2 body word read", rd_cnt[wa(s, 4)], 1);
    end
    check("R3 park slot3", rd_cnt[wa(3, 7)], 1);
    check("R5 writes", wr_tot, 3);
  endtask

  task automatic t_wrap();
    put_desc(3, 4); put_desc(0, 5);
    clr_stats();
    kick_and_wait();
    check("R7 parked slot re-read", rd_cnt[wa(3, 7)], 1);
    check("R6 wrap copies", log_n, 2);
    chk_log(0, 4); chk_log(1, 5);
    check("R6 park slot1", rd_cnt[wa(1, 7)], 1);
  endtask

  task automatic t_half();
    for (int w = 0; w < 6; w++) wr(wa(1, w), 32'h77 + w);
    wr(wa(1, 7), 0);
    clr_stats();
    kick_and_wait();
    check("R3 half-written only validity read", rd_tot, 1);
    check("R3 body not read", rd_cnt[wa(1, 0)], 0);
    check("R3 no copy", log_n, 0);
  endtask

  task automatic t_kick_busy();
    put_desc(1, 6);
    clr_stats();
    @(negedge clk); kick = 1;
    @(negedge clk); kick = 0;
    for (int i = 0; i < 100; i++) begin
      if (blit_valid) break;
      @(negedge clk);
    end
    kick = 1; @(negedge clk); kick = 1; @(negedge clk); kick = 0;
    for (int i = 0; i < 3000; i++) begin
      if (!busy) break;
      @(negedge clk);
    end
    check("R8 one copy", log_n, 1);
    chk_log(0, 6);
    check("R8 single extra recheck", rd_cnt[wa(2, 7)], 2);
    check("R8 idle", 32'(busy), 0);
  endtask

  task automatic t_stall();
    put_desc(2, 7); put_desc(3, 8);
    @(negedge clk); stall = 1;
    clr_stats();
    kick_and_wait();
    @(negedge clk); stall = 0;
    check("R10 stalled copies", log_n, 2);
    chk_log(0, 7); chk_log(1, 8);
    check("R10 reads exact", rd_tot, 15);
    check("R10 retire slot2", mem[wa(2, 7)], 0);
    check("R10 retire slot3", mem[wa(3, 7)], 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_empty();
    t_burst();
    t_wrap();
    t_half();
    t_kick_busy();
    t_stall();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule